// File: doc/BRIEF.md
# GART Control and Error Status Register

This block is the single 32-bit control and status word of an address-remapping (GART) unit. Software writes it to turn on caching of translation entries, to enable reporting of page-valid errors as a system error, to ask for the walker to freeze on illegal table entries, and to disable the sideband strobe toggle detector. Hardware uses the same word to record the first page-valid error together with a 2-bit code naming the requester that caused it.

While the recorded error is pending and reporting is enabled, the system-error output is held high. Any accepted page-valid error, and an illegal table entry when freezing is enabled, latches a hang output that stalls the table walker until reset. Read data is presented combinationally from the register state. Address decoding is done outside the block, so a write strobe means this register is selected.

Top module: `gart_ctl_stat_reg`

## Requirements
- R1: After reset the read word is 0x0000_0000, and sys_err_o, walk_hang_o, tlb_en_o and strobe_det_dis_o are all low.
- R2: A write loads bits 18 (translation caching enable), 17 (strobe detector disable), 16 (error reporting enable) and 11 (hang on illegal entry) from the write data. tlb_en_o follows bit 18 and strobe_det_dis_o follows bit 17.
- R3: Bit 26 always reads the same value as bit 18.
- R4: Bits 31:30, 27, 25, 23:19, 15:12 and 10:0 always read 0, including after writes of all ones.
- R5: On a clock edge where err_valid_i is high with an accepted source code, bit 24 is set. If bit 24 was clear, that code is stored in bits 29:28. The codes are 00 for graphics, 01 for CPU and 10 for PCI.
- R6: While bit 24 is set, later errors leave bits 29:28 unchanged.
- R7: Writing 1 to bit 24 clears it and resets bits 29:28 to 00. Writing 0 to bit 24 has no effect.
- R8: If an accepted error and a software clear of bit 24 occur on the same edge, bit 24 stays set and bits 29:28 take the new error's code.
- R9: sys_err_o is high exactly when bit 24 and bit 16 are both set.
- R10: An accepted error raises walk_hang_o on the next edge. walk_hang_o then stays high until reset.
- R11: When illegal_entry_i is high, walk_hang_o is raised only if bit 11 is set.
- R12: An error with the reserved source code 11 is ignored. It sets neither bit 24 nor walk_hang_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data |
| err_valid_i | input | 1 | Page-valid error event |
| err_src_i | input | 2 | Requester code of the error |
| illegal_entry_i | input | 1 | Walker fetched an illegal table entry |
| sys_err_o | output | 1 | System-error output |
| walk_hang_o | output | 1 | Stall request to the table walker |
| tlb_en_o | output | 1 | Translation caching enable |
| strobe_det_dis_o | output | 1 | Strobe toggle detector disable |

## Verification
A wrong pending flag shows up in the read word and in sys_err_o on the cycle after the error or clear edge. A wrongly overwritten or cleared source code therefore shows in bits 29:28 on the first read after a second error or a clear. A hang latch that fails to hold, or that sets on a blocked illegal entry, is visible on walk_hang_o one cycle after the event. The directed tests read the register back right after every step.

// File: rtl/gart_csr_pkg.sv
package gart_csr_pkg;
  localparam int REG_W    = 32;
  localparam int SRC_W    = 2;
  localparam int B_SRC_LO = 28;
  localparam int B_SRC_HI = B_SRC_LO + SRC_W - 1;
  localparam int B_P2P_ST = 27;
  localparam int B_CACHE  = 26;
  localparam int B_ERR    = 24;
  localparam int B_P2P_EN = 19;
  localparam int B_TLB    = 18;
  localparam int B_SBDIS  = 17;
  localparam int B_VEREN  = 16;
  localparam int B_HANGEN = 11;

  typedef enum logic [SRC_W-1:0] {
    SRC_GFX = 2'b00,
    SRC_CPU = 2'b01,
    SRC_PCI = 2'b10,
    SRC_RSV = 2'b11
  } src_e;

  typedef struct packed {
    logic tlb_en;
    logic sb_dis;
    logic verr_en;
    logic hang_en;
  } ctl_t;
endpackage

// File: rtl/gart_csr_ctrl.sv
module gart_csr_ctrl
  import gart_csr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  ctl_t wr_ctl_i,
  output ctl_t ctl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctl_o <= '0;
    else if (wr_en_i) ctl_o <= wr_ctl_i;
  end
endmodule

// File: rtl/gart_csr_err.sv
module gart_csr_err
  import gart_csr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             err_valid_i,
  input  logic [SRC_W-1:0] err_src_i,
  input  logic             clr_i,
  output logic             ev_o,
  output logic             flag_o,
  output logic [SRC_W-1:0] src_o
);
  // reserved requester code is dropped
  assign ev_o = err_valid_i && (err_src_i != SRC_RSV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      src_o  <= '0;
    end else if (ev_o && (!flag_o || clr_i)) begin
      // first capture, or set beats a same-cycle clear
      flag_o <= 1'b1;
      src_o  <= err_src_i;
    end else if (clr_i) begin
      flag_o <= 1'b0;
      src_o  <= '0;
    end
  end
endmodule

// File: rtl/gart_csr_hang.sv
module gart_csr_hang (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_i,
  input  logic illegal_i,
  input  logic hang_en_i,
  output logic hang_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              hang_o <= 1'b0;
    else if (ev_i || (illegal_i && hang_en_i)) hang_o <= 1'b1;
  end
endmodule

// File: rtl/gart_ctl_stat_reg.sv
module gart_ctl_stat_reg
  import gart_csr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             err_valid_i,
  input  logic [SRC_W-1:0] err_src_i,
  input  logic             illegal_entry_i,
  output logic             sys_err_o,
  output logic             walk_hang_o,
  output logic             tlb_en_o,
  output logic             strobe_det_dis_o
);
  ctl_t             ctl_q, wr_ctl;
  logic             ev, flag_q;
  logic [SRC_W-1:0] src_q;
  logic             unused_wr_bits;

  assign unused_wr_bits = ^wr_data_i;

  always_comb begin
    wr_ctl.tlb_en  = wr_data_i[B_TLB];
    wr_ctl.sb_dis  = wr_data_i[B_SBDIS];
    wr_ctl.verr_en = wr_data_i[B_VEREN];
    wr_ctl.hang_en = wr_data_i[B_HANGEN];
  end

  gart_csr_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_ctl_i (wr_ctl),
    .ctl_o    (ctl_q)
  );

  gart_csr_err u_err (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .err_valid_i (err_valid_i),
    .err_src_i   (err_src_i),
    .clr_i       (wr_en_i && wr_data_i[B_ERR]),
    .ev_o        (ev),
    .flag_o      (flag_q),
    .src_o       (src_q)
  );

  gart_csr_hang u_hang (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_i      (ev),
    .illegal_i (illegal_entry_i),
    .hang_en_i (ctl_q.hang_en),
    .hang_o    (walk_hang_o)
  );

  always_comb begin
    rd_data_o                   = '0;
    rd_data_o[B_SRC_HI:B_SRC_LO] = src_q;
    rd_data_o[B_P2P_ST]         = 1'b0;
    rd_data_o[B_CACHE]          = ctl_q.tlb_en;
    rd_data_o[B_ERR]            = flag_q;
    rd_data_o[B_P2P_EN]         = 1'b0;
    rd_data_o[B_TLB]            = ctl_q.tlb_en;
    rd_data_o[B_SBDIS]          = ctl_q.sb_dis;
    rd_data_o[B_VEREN]          = ctl_q.verr_en;
    rd_data_o[B_HANGEN]         = ctl_q.hang_en;
  end

  assign sys_err_o        = flag_q && ctl_q.verr_en;
  assign tlb_en_o         = ctl_q.tlb_en;
  assign strobe_det_dis_o = ctl_q.sb_dis;
endmodule

// File: rtl/gart_csr_chk.sv
module gart_csr_chk
  import gart_csr_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             err_valid_i,
  input logic [SRC_W-1:0] err_src_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             sys_err_o,
  input logic             walk_hang_o
);
  localparam logic [REG_W-1:0] LIVE_MASK = (REG_W'(3) << B_SRC_LO) | (REG_W'(1) << B_CACHE) |
                                           (REG_W'(1) << B_ERR) | (REG_W'(1) << B_TLB) |
                                           (REG_W'(1) << B_SBDIS) | (REG_W'(1) << B_VEREN) |
                                           (REG_W'(1) << B_HANGEN);

  logic acc_err;
  assign acc_err = err_valid_i && (err_src_i != SRC_RSV);

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~LIVE_MASK) == '0); // R4
  AST_CACHE_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[B_CACHE] == rd_data_o[B_TLB]); // R3
  AST_ERR_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_err |=> rd_data_o[B_ERR]); // R5
  AST_SRC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[B_ERR] && !wr_en_i |=> $stable(rd_data_o[B_SRC_HI:B_SRC_LO])); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[B_ERR] && !wr_en_i |=> rd_data_o[B_ERR]); // R7
  AST_SERR_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_err_o == (rd_data_o[B_ERR] && rd_data_o[B_VEREN])); // R9
  AST_HANG_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_err |=> walk_hang_o); // R10
  AST_HANG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_hang_o |=> walk_hang_o); // R10
  AST_NO_RSV_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[B_SRC_HI:B_SRC_LO] != SRC_RSV); // R12
endmodule

bind gart_ctl_stat_reg gart_csr_chk u_chk (.*);

// File: tb/sim_gart_ctl_stat_reg.sv
`timescale 1ns/1ps
module sim_gart_ctl_stat_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        err_valid = 1'b0;
  logic [1:0]  err_src = '0;
  logic        illegal = 1'b0;
  logic        sys_err, hang, tlb_en, sb_dis;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  gart_ctl_stat_reg u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .err_valid_i(err_valid), .err_src_i(err_src), .illegal_entry_i(illegal),
    .sys_err_o(sys_err), .walk_hang_o(hang), .tlb_en_o(tlb_en), .strobe_det_dis_o(sb_dis)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // drive one cycle at negedge; results sampled at the following negedge
  task automatic step(input logic we, input logic [31:0] wd, input logic ev,
                      input logic [1:0] src, input logic ill);
    @(negedge clk);
    wr_en = we; wr_data = wd; err_valid = ev; err_src = src; illegal = ill;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; err_valid = 1'b0; err_src = '0; illegal = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 rd", rd_data, 32'h0);
    chk("R1 outs", {28'h0, sys_err, hang, tlb_en, sb_dis}, 32'h0);
  endtask

  task automatic t_ctrl();
    do_reset();
    step(1, 32'hFFFF_FFFF, 0, 2'b00, 0);
    chk("R2 R3 R4 all-ones write", rd_data, 32'h0407_0800);
    chk("R2 outputs", {30'h0, tlb_en, sb_dis}, 32'h3);
    step(1, 32'h0004_0000, 0, 2'b00, 0);
    chk("R3 cache mirror", rd_data, 32'h0404_0000);
    chk("R2 sb_dis low", {31'h0, sb_dis}, 32'h0);
    step(1, 32'h0000_0000, 0, 2'b00, 0);
    chk("R2 cleared", rd_data, 32'h0);
  endtask

  task automatic t_err_cpu();
    do_reset();
    step(1, 32'h0001_0000, 0, 2'b00, 0);
    step(0, 32'h0, 1, 2'b01, 0);
    chk("R5 capture CPU", rd_data, 32'h1101_0000);
    chk("R9 sys_err high", {31'h0, sys_err}, 32'h1);
    chk("R10 hang raised", {31'h0, hang}, 32'h1);
    step(0, 32'h0, 1, 2'b10, 0);
    chk("R6 source held", rd_data, 32'h1101_0000);
    step(1, 32'h0001_0000, 0, 2'b00, 0);
    chk("R7 write 0 no effect", rd_data, 32'h1101_0000);
    step(1, 32'h0101_0000, 0, 2'b00, 0);
    chk("R7 W1C", rd_data, 32'h0001_0000);
    chk("R9 sys_err low", {31'h0, sys_err}, 32'h0);
    chk("R10 hang sticky", {31'h0, hang}, 32'h1);
  endtask

  task automatic t_set_wins();
    do_reset();
    step(0, 32'h0, 1, 2'b00, 0);
    chk("R5 capture GFX", rd_data, 32'h0100_0000);
    chk("R9 sys_err off when disabled", {31'h0, sys_err}, 32'h0);
    step(1, 32'h0100_0000, 1, 2'b10, 0);
    chk("R8 set wins", rd_data, 32'h2100_0000);
  endtask

  task automatic t_rsv_src();
    do_reset();
    step(0, 32'h0, 1, 2'b11, 0);
    chk("R12 flag", rd_data, 32'h0);
    chk("R12 hang", {31'h0, hang}, 32'h0);
  endtask

  task automatic t_illegal();
    do_reset();
    step(0, 32'h0, 0, 2'b00, 1);
    chk("R11 blocked", {31'h0, hang}, 32'h0);
    step(1, 32'h0000_0800, 0, 2'b00, 0);
    step(0, 32'h0, 0, 2'b00, 1);
    chk("R11 hang set", {31'h0, hang}, 32'h1);
    chk("R11 flag untouched", rd_data, 32'h0000_0800);
  endtask

  initial begin
    t_reset();
    t_ctrl();
    t_err_cpu();
    t_set_wins();
    t_rsv_src();
    t_illegal();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule